// File: doc/BRIEF.md
# Memory-to-Packet-Bus DMA Transmit Controller

This block moves a run of consecutive words out of a memory and onto an on-chip packet bus. A controller loads four configuration values: a destination bus address, a source memory byte address, a word count and a 5-bit command code. It then pulses a start input. The block fetches the words through a pipelined read master. That master holds its request while the slave asserts waitrequest, and it accepts returning data only when readdatavalid is high.

On the packet bus each transfer opens with one header word. The header carries the destination address and has address-valid raised. The fetched words follow in memory order with address-valid low. Every word carries the latched command code. The bus may raise a full signal at any time. Words that arrive from memory while the bus is blocked wait in a small response buffer. The read master stops issuing requests as soon as that buffer could not absorb every response still in flight. A done output is high whenever the block is idle and ready for the next start pulse.

Top module: `mem2bus_tx_dma`

## Requirements
- R1: While reset (asynchronous, active low) is asserted, and whenever the block is idle: done = 1, mem_rd = 0, pb_we = 0 and pb_cmd = 5'b00000, which is the idle code.
- R2: A start pulse seen while done = 1 latches cfg_cmd, cfg_dest, cfg_src and cfg_count, and done is 0 in the following cycle. A start pulse while done = 0 is ignored. Configuration inputs that change during a transfer have no effect on it.
- R3: The first packet-bus word of a transfer has pb_av = 1 and pb_data = the latched destination. It is followed by exactly cfg_count words with pb_av = 0, each equal to the memory word at src + 4*k for k = 0, 1, 2 and so on. A count of 0 sends the header alone.
- R4: A word moves only in a cycle with pb_we = 1 and pb_full = 0. While pb_full is high, pb_we, pb_data, pb_av and pb_cmd hold. No word is lost or repeated. Every word carries the latched command code (for example write 5'b00010 or message write 5'b00011).
- R5: The k-th accepted read has mem_addr = src + 4*k, modulo 2^32. While mem_rd = 1 and mem_wait = 1, mem_rd and mem_addr hold. A read counts as accepted only in a cycle with mem_wait = 0.
- R6: mem_rdata is taken only in cycles with mem_rvalid = 1. A mem_rvalid pulse while no read is outstanding is ignored.
- R7: Exactly cfg_count reads are accepted per transfer. The count of accepted reads minus data words written never exceeds FIFO_DEPTH.
- R8: done returns to 1 in the cycle after the last data word has been written, or after the header when the count is 0. A new start is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_start | input | 1 | Single-cycle start pulse |
| cfg_cmd | input | 5 | Command code for the packet bus |
| cfg_dest | input | DATA_W | Destination address sent in the header word |
| cfg_src | input | ADDR_W | Source memory byte address |
| cfg_count | input | CNT_W | Number of data words |
| done | output | 1 | High while idle |
| mem_rd | output | 1 | Read request strobe |
| mem_addr | output | ADDR_W | Read byte address |
| mem_wait | input | 1 | Slave stalls the request |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read data valid |
| pb_we | output | 1 | Packet-bus write enable |
| pb_av | output | 1 | Packet-bus address-valid (header word) |
| pb_data | output | DATA_W | Packet-bus word |
| pb_cmd | output | 5 | Packet-bus command |
| pb_full | input | 1 | Packet bus cannot take a word |

## Verification
The bench builds the block with its defaults: 32-bit words and addresses, a 9-bit count and a 4-entry response buffer. The 9-bit count brings the largest transfer (511 words) and the empty transfer within reach. The 4-entry buffer is small enough that a bus held full for long stretches, combined with one-cycle read responses, drives the read credit to its limit. A source address near the top of the address space makes the read address wrap.

// File: rtl/dma_tx_pkg.sv
package dma_tx_pkg;
  localparam int CMD_W = 5;
  localparam logic [CMD_W-1:0] CMD_IDLE = 5'b00000;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_HEAD = 2'd1,
    WS_BODY = 2'd2
  } wr_state_e;
endpackage

// File: rtl/dma_tx_fifo.sv
module dma_tx_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] count,
  output logic          empty
);
  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_r;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_r  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      cnt_r <= cnt_r + CW'(push) - CW'(pop);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && (wr_ptr == PW'(g))) store[g] <= din;
    end
  end

  assign dout  = store[rd_ptr];
  assign count = cnt_r;
  assign empty = (cnt_r == '0);
endmodule

// File: rtl/dma_tx_rd_issuer.sv
module dma_tx_rd_issuer #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 9,
  parameter int DEPTH  = 4,
  parameter int STRIDE = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] src,
  input  logic [CNT_W-1:0]  count,
  input  logic [CW-1:0]     buf_count,
  input  logic              mem_wait,
  input  logic              mem_rvalid,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              rd_accept,
  output logic              rsp_take,
  output logic [CW-1:0]     slots_used
);
  logic [ADDR_W-1:0] addr_r;
  logic [CNT_W-1:0]  left_r;
  logic [CW-1:0]     outst_r;

  function automatic logic [ADDR_W-1:0] next_rd_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(STRIDE);
  endfunction

  // Buffer entries already holding data plus reads whose data is still due.
  assign slots_used = buf_count + outst_r;
  assign mem_rd     = (left_r != '0) && (slots_used < CW'(DEPTH));
  assign rd_accept  = mem_rd && !mem_wait;
  assign rsp_take   = mem_rvalid && (outst_r != '0);
  assign mem_addr   = addr_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_r  <= '0;
      left_r  <= '0;
      outst_r <= '0;
    end else begin
      if (load) begin
        addr_r <= src;
        left_r <= count;
      end else if (rd_accept) begin
        addr_r <= next_rd_addr(addr_r);
        left_r <= left_r - CNT_W'(1);
      end
      outst_r <= outst_r + CW'(rd_accept) - CW'(rsp_take);
    end
  end
endmodule

// File: rtl/mem2bus_tx_dma.sv
module mem2bus_tx_dma
  import dma_tx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 9,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_start,
  input  logic [CMD_W-1:0]  cfg_cmd,
  input  logic [DATA_W-1:0] cfg_dest,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [CNT_W-1:0]  cfg_count,
  output logic              done,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_wait,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              pb_we,
  output logic              pb_av,
  output logic [DATA_W-1:0] pb_data,
  output logic [CMD_W-1:0]  pb_cmd,
  input  logic              pb_full
);
  localparam int BYTES = DATA_W / 8;
  localparam int SW    = $clog2(FIFO_DEPTH + 1);

  wr_state_e         state_r;
  logic [DATA_W-1:0] dest_r;
  logic [CMD_W-1:0]  cmd_r;
  logic [CNT_W-1:0]  wr_left_r;

  // Named internal events.
  logic              start_ok;
  logic              wr_fire;
  logic              body_pop;
  logic              rd_accept;
  logic              rsp_take;
  logic [SW-1:0]     slots_used;
  logic [SW-1:0]     buf_count;
  logic              buf_empty;
  logic [DATA_W-1:0] buf_dout;

  assign start_ok = cfg_start && (state_r == WS_IDLE);
  assign wr_fire  = pb_we && !pb_full;
  assign body_pop = wr_fire && (state_r == WS_BODY);
  assign done     = (state_r == WS_IDLE);

  always_comb begin
    pb_we   = 1'b0;
    pb_av   = 1'b0;
    pb_data = '0;
    pb_cmd  = CMD_IDLE;
    unique case (state_r)
      WS_HEAD: begin
        pb_we   = 1'b1;
        pb_av   = 1'b1;
        pb_data = dest_r;
        pb_cmd  = cmd_r;
      end
      WS_BODY: begin
        pb_we   = !buf_empty;
        pb_data = buf_dout;
        pb_cmd  = cmd_r;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_r   <= WS_IDLE;
      dest_r    <= '0;
      cmd_r     <= CMD_IDLE;
      wr_left_r <= '0;
    end else begin
      unique case (state_r)
        WS_IDLE: if (start_ok) begin
          dest_r    <= cfg_dest;
          cmd_r     <= cfg_cmd;
          wr_left_r <= cfg_count;
          state_r   <= WS_HEAD;
        end
        WS_HEAD: if (wr_fire) begin
          state_r <= (wr_left_r == '0) ? WS_IDLE : WS_BODY;
        end
        WS_BODY: if (body_pop) begin
          wr_left_r <= wr_left_r - CNT_W'(1);
          if (wr_left_r == CNT_W'(1)) state_r <= WS_IDLE;
        end
        default: state_r <= WS_IDLE;
      endcase
    end
  end

  dma_tx_rd_issuer #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH), .STRIDE(BYTES)
  ) rd_i (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .src(cfg_src), .count(cfg_count),
    .buf_count(buf_count), .mem_wait(mem_wait), .mem_rvalid(mem_rvalid),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .rd_accept(rd_accept),
    .rsp_take(rsp_take), .slots_used(slots_used)
  );

  dma_tx_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) buf_i (
    .clk(clk), .rst_n(rst_n), .push(rsp_take), .din(mem_rdata), .pop(body_pop),
    .dout(buf_dout), .count(buf_count), .empty(buf_empty)
  );
endmodule

// File: rtl/dma_tx_checker.sv
module dma_tx_checker #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 4,
  localparam int SW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_start,
  input logic              done,
  input logic              mem_rd,
  input logic              mem_wait,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              pb_we,
  input logic              pb_full,
  input logic              pb_av,
  input logic [DATA_W-1:0] pb_data,
  input logic [4:0]        pb_cmd,
  input logic [SW-1:0]     slots_used
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_rd && !pb_we && pb_cmd == 5'b00000)); // R1

  AST_DONE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cfg_start) |=> !done); // R2

  AST_HEADER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> (pb_we && pb_av)); // R3

  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_we && pb_full) |=> (pb_we && $stable(pb_data) && $stable(pb_av) && $stable(pb_cmd))); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_wait) |=> (mem_rd && $stable(mem_addr))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    slots_used <= SW'(FIFO_DEPTH)); // R7

  AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pb_we && !pb_full)); // R8
endmodule

bind mem2bus_tx_dma dma_tx_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .done(done),
  .mem_rd(mem_rd), .mem_wait(mem_wait), .mem_addr(mem_addr),
  .pb_we(pb_we), .pb_full(pb_full), .pb_av(pb_av), .pb_data(pb_data),
  .pb_cmd(pb_cmd), .slots_used(slots_used)
);

// File: tb/mem2bus_tx_dma_tb_top.sv
`timescale 1ns/1ps
module mem2bus_tx_dma_tb_top;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_start = 1'b0;
  logic [4:0]  cfg_cmd = 5'd0;
  logic [31:0] cfg_dest = '0;
  logic [31:0] cfg_src = '0;
  logic [8:0]  cfg_count = '0;
  logic        done, mem_rd, pb_we, pb_av;
  logic [31:0] mem_addr, pb_data;
  logic [4:0]  pb_cmd;
  logic        mem_wait = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rvalid = 1'b0;
  logic        pb_full = 1'b0;

  always #2 clk = ~clk;

  mem2bus_tx_dma dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_cmd(cfg_cmd),
    .cfg_dest(cfg_dest), .cfg_src(cfg_src), .cfg_count(cfg_count), .done(done),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wait(mem_wait), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .pb_we(pb_we), .pb_av(pb_av), .pb_data(pb_data),
    .pb_cmd(pb_cmd), .pb_full(pb_full)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit hung = 0;

  bit          in_xfer = 0, start_prev = 0, last_fire_prev = 0, start_req = 0, stray = 0;
  logic [4:0]  x_cmd;
  logic [31:0] x_dest, x_src;
  int          x_cnt, nacc, ndat, nhdr;
  logic [31:0] rspq[$];
  int          full_pct = 0, wait_pct = 0, rv_pct = 100;
  logic        p_we = 0, p_full = 0, p_av = 0, p_rd = 0, p_wait = 0;
  logic [31:0] p_data = '0, p_addr = '0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[7:0] ^ 8'hC3, a[31:8]};
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int k);
    return base + 32'(k * 4);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 190000) hung = 1;
    if (p_we && p_full)
      chk(pb_we && pb_data == p_data && pb_av == p_av, "R4 word held while full", pb_data, p_data);
    if (p_rd && p_wait)
      chk(mem_rd && mem_addr == p_addr, "R5 request held while waitrequest", mem_addr, p_addr);
    if (start_prev) begin
      chk(!done, "R2 done low after start", 32'(done), 32'd0);
      start_prev = 0;
    end else if (last_fire_prev) begin
      chk(done, "R8 done high after last word", 32'(done), 32'd1);
      in_xfer = 0;
      last_fire_prev = 0;
    end else if (in_xfer && done) begin
      chk(1'b0, "R8 done stays low during transfer", 32'(done), 32'd0);
    end
    cfg_start = start_req;
    if (start_req && done) begin
      in_xfer = 1; start_prev = 1;
      x_cmd = cfg_cmd; x_dest = cfg_dest; x_src = cfg_src; x_cnt = int'(cfg_count);
      nacc = 0; ndat = 0; nhdr = 0;
      rspq.delete();
    end
    pb_full  = ($urandom_range(99) < full_pct);
    mem_wait = ($urandom_range(99) < wait_pct);
    if (rspq.size() > 0 && $urandom_range(99) < rv_pct) begin
      mem_rvalid = 1'b1;
      mem_rdata  = rspq.pop_front();
    end else begin
      mem_rvalid = stray && !in_xfer;
      mem_rdata  = $urandom();
    end
    if (mem_rd && !mem_wait) begin
      chk(in_xfer && nacc < x_cnt, "R7 read within count", 32'(nacc), 32'(x_cnt));
      chk(mem_addr == exp_addr(x_src, nacc), "R5 read address", mem_addr, exp_addr(x_src, nacc));
      rspq.push_back(mem_word(mem_addr));
      nacc++;
      chk(nacc - ndat <= DEPTH, "R7 buffer credit", 32'(nacc - ndat), 32'(DEPTH));
    end
    if (pb_we && !pb_full) begin
      if (!in_xfer) chk(1'b0, "R2 no write while idle", pb_data, 32'd0);
      else begin
        chk(pb_cmd == x_cmd, "R4 command on word", 32'(pb_cmd), 32'(x_cmd));
        if (pb_av) begin
          chk(nhdr == 0 && pb_data == x_dest, "R3 header word", pb_data, x_dest);
          nhdr++;
          if (x_cnt == 0) last_fire_prev = 1;
        end else begin
          chk(nhdr == 1 && ndat < x_cnt && pb_data == mem_word(exp_addr(x_src, ndat)),
              "R3 data word in memory order", pb_data, mem_word(exp_addr(x_src, ndat)));
          ndat++;
          if (ndat == x_cnt) last_fire_prev = 1;
        end
      end
    end
    p_we = pb_we; p_full = pb_full; p_av = pb_av; p_data = pb_data;
    p_rd = mem_rd; p_wait = mem_wait; p_addr = mem_addr;
  endtask

  task automatic run_xfer(input logic [4:0] c, input logic [31:0] d, input logic [31:0] s,
                          input int n, input int fp, input int wp, input int rp, input bit intrude);
    cfg_cmd = c; cfg_dest = d; cfg_src = s; cfg_count = 9'(n);
    full_pct = fp; wait_pct = wp; rv_pct = rp;
    start_req = 1; step(); start_req = 0;
    chk(in_xfer, "R2 start accepted while done high", 32'(in_xfer), 32'd1);
    for (int i = 0; i < 40000 && in_xfer && !hung; i++) begin
      if (intrude && i == 3) begin
        cfg_cmd = ~c; cfg_dest = ~d; cfg_src = ~s; cfg_count = 9'(n + 5);
        start_req = 1;
      end else start_req = 0;
      step();
    end
    start_req = 0;
    if (in_xfer) begin
      chk(1'b0, "R8 transfer completes", 32'd0, 32'd1);
      hung = 1;
      in_xfer = 0;
    end
    chk(nacc == n, "R7 read count", 32'(nacc), 32'(n));
    chk(ndat == n, "R3 data word count", 32'(ndat), 32'(n));
    chk(nhdr == 1, "R3 single header", 32'(nhdr), 32'd1);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(done && !pb_we && !mem_rd && pb_cmd == 5'b00000, "R1 idle outputs between transfers",
          {28'd0, done, pb_we, mem_rd, |pb_cmd}, 32'h8);
    end
  endtask

  initial begin
    int f0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    #1;
    chk(done && !mem_rd && !pb_we && pb_cmd == 5'b00000, "R1 reset state",
        {28'd0, done, mem_rd, pb_we, |pb_cmd}, 32'h8);
    step(); step();
    rst_n = 1'b1;
    step();

    // R6: stray readdatavalid while idle, then a transfer whose data must be clean.
    stray = 1;
    repeat (5) step();
    stray = 0;
    f0 = n_fail;
    run_xfer(5'b00010, 32'd230, 32'd8, 1, 90, 0, 100, 0);
    chk(n_fail == f0, "R6 stray readdatavalid ignored", 32'(n_fail - f0), 32'd0);

    run_xfer(5'b00010, 32'h1234_5678, 32'h100, 0, 50, 0, 100, 0);          // header only
    run_xfer(5'b00011, 32'hCAFE_0001, 32'h4000, 511, 30, 30, 70, 0);      // max count
    run_xfer(5'b00010, 32'h0000_FBFE, 32'h200, 40, 95, 0, 100, 0);        // long full: R7 credit
    run_xfer(5'b00011, 32'h0000_0015, 32'hFFFF_FFF0, 8, 20, 50, 60, 0);   // address wrap
    run_xfer(5'b00010, 32'h0000_025A, 32'h0000_0028, 30, 40, 20, 80, 1);  // R2 intruding start
    run_xfer(5'b00010, 32'd54, 32'd12, 14, 0, 90, 100, 0);                // heavy waitrequest

    for (int t = 0; t < 12 && !hung; t++) begin
      run_xfer($urandom_range(1) ? 5'b00011 : 5'b00010, $urandom(),
               {$urandom_range(32'h3FFF_FFFF), 2'b00}, $urandom_range(60, 1),
               $urandom_range(80), $urandom_range(60), $urandom_range(100, 30), 0);
    end

    // R1: reset in the middle of a transfer.
    cfg_cmd = 5'b00010; cfg_dest = 32'hABCD; cfg_src = 32'h800; cfg_count = 9'd50;
    full_pct = 50; wait_pct = 10; rv_pct = 80;
    start_req = 1; step(); start_req = 0;
    repeat (20) step();
    #0.2 rst_n = 1'b0;
    #0.5;
    chk(done && !mem_rd && !pb_we && pb_cmd == 5'b00000, "R1 reset mid-transfer",
        {28'd0, done, mem_rd, pb_we, |pb_cmd}, 32'h8);
    in_xfer = 0; start_prev = 0; last_fire_prev = 0; rspq.delete();
    mem_rvalid = 1'b0;
    p_we = 0; p_rd = 0;
    step(); step();
    rst_n = 1'b1;
    step();
    run_xfer(5'b00011, 32'h600D, 32'h40, 6, 30, 30, 80, 0);               // R8 recovery

    if (hung) chk(1'b0, "R8 watchdog", 32'(cyc), 32'd190000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule